// File: doc/BRIEF.md
# Class-of-Service Cache Mask Table

The block holds the way-allocation masks that a two-level shared cache applies to each class of service. Each hardware thread owns an association register, and that register holds a class number. The cache presents the thread that is making an access. One cycle later the block returns three masks for that thread's class: the level-2 mask, a level-3 code mask and a level-3 data mask. The level-2 table and the level-3 table can have different depths, but the same class number indexes both. When a class lies beyond a table's depth, that level gets an all-ones mask, so nothing at that level is restricted.

The level-3 table works in one of two modes. In unified mode one entry per class drives both level-3 outputs. In split mode, selected by the `cdp_en` input, each class owns an adjacent pair of entries: one gives separate code ways and the other separate data ways. Split mode therefore halves the number of classes that level 3 can serve. Software programs the tables through a register port addressed by register number. A mask write is accepted only if its set bits form one non-empty contiguous run. A refused write changes nothing and raises a one-cycle error pulse.

Top module: `cos_mask_table`

## Requirements
- R1: After reset every thread holds class 0. Every mask entry and every mask output is all ones, and `err` and `rd_valid` are low.
- R2: Level-2 mask entry n sits at register 0xD10+n for n < L2_CLASSES. Only the low L2_MW bits of a write are stored, and a read of the entry returns them zero-extended.
- R3: A mask write is refused when its stored bits are zero or are not one contiguous run of ones. A refused write leaves the entry unchanged, and `err` is high for exactly the cycle after the write.
- R4: The class register of thread t sits at 0x100+t. It stores the low CLS_W bits of the write, and that one class number selects both the level-2 and the level-3 masks.
- R5: The mask outputs are registered. They reflect the class held by `lk_thread` at the previous clock edge, so a class change shows on the outputs one cycle after the register is written.
- R6: A class of L2_CLASSES or above drives an all-ones `l2_mask`.
- R7: With `cdp_en` low, level-3 entry c drives both `l3_code_mask` and `l3_data_mask`. A class of L3_ENTRIES or above drives all ones on both.
- R8: With `cdp_en` high, class c takes its data mask from entry 2c and its code mask from entry 2c+1. A class of L3_ENTRIES/2 or above drives all ones on both.
- R9: Level-3 mask entry n sits at 0xC90+n for n < L3_ENTRIES. It stores the low L3_MW bits of a write and reads them back zero-extended.
- R10: A write to an address that maps to no register is refused and pulses `err`. A read of such an address returns zero.
- R11: A read request gives `rd_valid` high, with the register value on `rd_data`, in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Register request present this cycle |
| req_write | input | 1 | Request is a write (1) or a read (0) |
| req_addr | input | 12 | Register number |
| req_wdata | input | 32 | Write data |
| lk_thread | input | THR_W | Thread making the cache access |
| cdp_en | input | 1 | Split level-3 code/data mode |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| err | output | 1 | One-cycle pulse for a refused write |
| l2_mask | output | L2_MW | Level-2 way mask for the thread's class |
| l3_code_mask | output | L3_MW | Level-3 code way mask |
| l3_data_mask | output | L3_MW | Level-3 data way mask |

## Verification
The bench uses four threads, 4-bit class numbers, a 4-entry 8-bit level-2 table and an 8-entry 12-bit level-3 table. With these values one set of thread classes (1, 3, 5 and 9) covers every region of the lookup. Class 3 is in range for both levels. Class 5 is beyond the level-2 table and, in split mode, beyond the halved level-3 range, but it is still valid in unified mode. Class 9 is beyond both tables. The bench also writes class values that exceed the 4-bit field, and mask words whose upper bits exceed the mask width, which checks that only the low bits are kept.

// File: rtl/cos_pkg.sv
// Shared definitions for the class-of-service mask table.
// Assumes register numbers are 12 bits and data words are 32 bits.
package cos_pkg;
    localparam int unsigned REG_AW = 12;
    localparam int unsigned REG_DW = 32;
    localparam logic [11:0] ASSOC_BASE = 12'h100;
    localparam logic [11:0] L3_BASE    = 12'hC90;
    localparam logic [11:0] L2_BASE    = 12'hD10;

    typedef enum logic [1:0] {
        TGT_NONE,
        TGT_ASSOC,
        TGT_L2,
        TGT_L3
    } cos_tgt_e;

    // True when v is non-zero and its set bits form one unbroken run.
    function automatic logic run_of_ones(input logic [63:0] v);
        logic [63:0] lowest;
        lowest = v & (~v + 64'd1);
        return (v != 64'd0) && (((v + lowest) & v) == 64'd0);
    endfunction
endpackage

// File: rtl/cos_reg_decode.sv
// Address decoder: maps a register number to a target table and an entry index.
// Assumes every table has at most 64 entries and that the ranges do not overlap.
module cos_reg_decode
    import cos_pkg::*;
#(
    parameter int unsigned NUM_THREADS = 4,
    parameter int unsigned L2_CLASSES  = 4,
    parameter int unsigned L3_ENTRIES  = 8
) (
    input  logic [REG_AW-1:0] addr,
    output cos_tgt_e          tgt,
    output logic [5:0]        idx
);
    logic [REG_AW-1:0] off_assoc;
    logic [REG_AW-1:0] off_l2;
    logic [REG_AW-1:0] off_l3;

    // Offsets of the address from each table base.
    always_comb begin
        off_assoc = addr - ASSOC_BASE;
        off_l2    = addr - L2_BASE;
        off_l3    = addr - L3_BASE;
    end

    // Pick the table whose range contains the address.
    always_comb begin
        tgt = TGT_NONE;
        idx = 6'd0;
        if (addr >= ASSOC_BASE && off_assoc < REG_AW'(NUM_THREADS)) begin
            tgt = TGT_ASSOC;
            idx = off_assoc[5:0];
        end else if (addr >= L2_BASE && off_l2 < REG_AW'(L2_CLASSES)) begin
            tgt = TGT_L2;
            idx = off_l2[5:0];
        end else if (addr >= L3_BASE && off_l3 < REG_AW'(L3_ENTRIES)) begin
            tgt = TGT_L3;
            idx = off_l3[5:0];
        end
    end
endmodule

// File: rtl/cos_entry_bank.sv
// Register bank of DEPTH entries of WIDTH bits with one write port.
// Every entry is visible at once. RESET_ONES picks all-ones or all-zeros reset.
// The caller checks the write data before it raises wr_en.
module cos_entry_bank #(
    parameter int unsigned DEPTH      = 4,
    parameter int unsigned WIDTH      = 8,
    parameter bit          RESET_ONES = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [5:0]       wr_idx,
    input  logic [WIDTH-1:0] wr_val,
    output logic [WIDTH-1:0] ents [DEPTH]
);
    logic [WIDTH-1:0] rst_val;

    generate
        if (RESET_ONES) begin : g_rst_ones
            assign rst_val = '1;
        end else begin : g_rst_zero
            assign rst_val = '0;
        end
    endgenerate

    // Reset every entry, or update the addressed entry.
    always_ff @(posedge clk) begin
        for (int i = 0; i < int'(DEPTH); i++) begin
            if (!rst_n) begin
                ents[i] <= rst_val;
            end else if (wr_en && wr_idx == 6'(i)) begin
                ents[i] <= wr_val;
            end
        end
    end
endmodule

// File: rtl/cos_lookup.sv
// Turns a class number into the three way masks, with one register stage.
// A class beyond a table's range yields all ones. Split mode pairs level-3 entries.
// Assumes L2_CLASSES and L3_ENTRIES do not exceed 2**CLS_W and L3_ENTRIES is even.
module cos_lookup #(
    parameter int unsigned CLS_W      = 4,
    parameter int unsigned L2_CLASSES = 4,
    parameter int unsigned L3_ENTRIES = 8,
    parameter int unsigned L2_MW      = 8,
    parameter int unsigned L3_MW      = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CLS_W-1:0] cls,
    input  logic             split_en,
    input  logic [L2_MW-1:0] l2_ents [L2_CLASSES],
    input  logic [L3_MW-1:0] l3_ents [L3_ENTRIES],
    output logic [L2_MW-1:0] l2_mask,
    output logic [L3_MW-1:0] l3_code_mask,
    output logic [L3_MW-1:0] l3_data_mask
);
    localparam int unsigned L3_PAIRS = L3_ENTRIES / 2;

    logic [L2_MW-1:0] l2_nxt;
    logic [L3_MW-1:0] code_nxt;
    logic [L3_MW-1:0] data_nxt;

    // Level-2 selection, all ones when the class is out of range.
    always_comb begin
        l2_nxt = '1;
        for (int i = 0; i < int'(L2_CLASSES); i++) begin
            if (int'(cls) == i) l2_nxt = l2_ents[i];
        end
    end

    // Level-3 selection, unified or paired by mode.
    always_comb begin
        code_nxt = '1;
        data_nxt = '1;
        if (!split_en) begin
            for (int i = 0; i < int'(L3_ENTRIES); i++) begin
                if (int'(cls) == i) begin
                    code_nxt = l3_ents[i];
                    data_nxt = l3_ents[i];
                end
            end
        end else begin
            for (int p = 0; p < int'(L3_PAIRS); p++) begin
                if (int'(cls) == p) begin
                    data_nxt = l3_ents[2*p];
                    code_nxt = l3_ents[2*p+1];
                end
            end
        end
    end

    // Output register stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            l2_mask      <= '1;
            l3_code_mask <= '1;
            l3_data_mask <= '1;
        end else begin
            l2_mask      <= l2_nxt;
            l3_code_mask <= code_nxt;
            l3_data_mask <= data_nxt;
        end
    end
endmodule

// File: rtl/cos_mask_table.sv
// Top of the class-of-service mask table: per-thread class registers,
// level-2 and level-3 mask banks, write checking, read-back and lookup.
// Assumes one register request per cycle. Read data and err are registered.
module cos_mask_table
    import cos_pkg::*;
#(
    parameter int unsigned NUM_THREADS = 4,
    parameter int unsigned CLS_W       = 4,
    parameter int unsigned L2_CLASSES  = 4,
    parameter int unsigned L3_ENTRIES  = 8,
    parameter int unsigned L2_MW       = 8,
    parameter int unsigned L3_MW       = 12,
    localparam int unsigned THR_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [11:0]       req_addr,
    input  logic [31:0]       req_wdata,
    input  logic [THR_W-1:0]  lk_thread,
    input  logic              cdp_en,
    output logic              rd_valid,
    output logic [31:0]       rd_data,
    output logic              err,
    output logic [L2_MW-1:0]  l2_mask,
    output logic [L3_MW-1:0]  l3_code_mask,
    output logic [L3_MW-1:0]  l3_data_mask
);
    cos_tgt_e          tgt;
    logic [5:0]        idx;
    logic              wr_req;
    logic              accept;
    logic [31:0]       rd_nxt;
    logic [CLS_W-1:0]  lk_cls;
    logic              unused_wdata;

    logic [CLS_W-1:0]  assoc_ents [NUM_THREADS];
    logic [L2_MW-1:0]  l2_ents    [L2_CLASSES];
    logic [L3_MW-1:0]  l3_ents    [L3_ENTRIES];

    assign unused_wdata = ^req_wdata;
    assign wr_req       = req_valid && req_write;

    cos_reg_decode #(
        .NUM_THREADS (NUM_THREADS),
        .L2_CLASSES  (L2_CLASSES),
        .L3_ENTRIES  (L3_ENTRIES)
    ) u_dec (
        .addr (req_addr),
        .tgt  (tgt),
        .idx  (idx)
    );

    // Decide whether the write is taken: class writes always, masks only if contiguous.
    always_comb begin
        unique case (tgt)
            TGT_ASSOC: accept = 1'b1;
            TGT_L2:    accept = run_of_ones(64'(req_wdata[L2_MW-1:0]));
            TGT_L3:    accept = run_of_ones(64'(req_wdata[L3_MW-1:0]));
            default:   accept = 1'b0;
        endcase
    end

    cos_entry_bank #(
        .DEPTH      (NUM_THREADS),
        .WIDTH      (CLS_W),
        .RESET_ONES (1'b0)
    ) u_assoc (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_req && accept && tgt == TGT_ASSOC),
        .wr_idx (idx),
        .wr_val (req_wdata[CLS_W-1:0]),
        .ents   (assoc_ents)
    );

    cos_entry_bank #(
        .DEPTH      (L2_CLASSES),
        .WIDTH      (L2_MW),
        .RESET_ONES (1'b1)
    ) u_l2 (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_req && accept && tgt == TGT_L2),
        .wr_idx (idx),
        .wr_val (req_wdata[L2_MW-1:0]),
        .ents   (l2_ents)
    );

    cos_entry_bank #(
        .DEPTH      (L3_ENTRIES),
        .WIDTH      (L3_MW),
        .RESET_ONES (1'b1)
    ) u_l3 (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_req && accept && tgt == TGT_L3),
        .wr_idx (idx),
        .wr_val (req_wdata[L3_MW-1:0]),
        .ents   (l3_ents)
    );

    // Read-back multiplexer over all tables. Unmapped addresses read as zero.
    always_comb begin
        rd_nxt = '0;
        unique case (tgt)
            TGT_ASSOC: begin
                for (int i = 0; i < int'(NUM_THREADS); i++)
                    if (idx == 6'(i)) rd_nxt = 32'(assoc_ents[i]);
            end
            TGT_L2: begin
                for (int i = 0; i < int'(L2_CLASSES); i++)
                    if (idx == 6'(i)) rd_nxt = 32'(l2_ents[i]);
            end
            TGT_L3: begin
                for (int i = 0; i < int'(L3_ENTRIES); i++)
                    if (idx == 6'(i)) rd_nxt = 32'(l3_ents[i]);
            end
            default: rd_nxt = '0;
        endcase
    end

    // Register read data, read valid and the refusal pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
            err      <= 1'b0;
        end else begin
            rd_valid <= req_valid && !req_write;
            err      <= wr_req && !accept;
            if (req_valid && !req_write) rd_data <= rd_nxt;
        end
    end

    // Class of the thread making the access.
    always_comb begin
        lk_cls = '0;
        for (int t = 0; t < int'(NUM_THREADS); t++)
            if (int'(lk_thread) == t) lk_cls = assoc_ents[t];
    end

    cos_lookup #(
        .CLS_W      (CLS_W),
        .L2_CLASSES (L2_CLASSES),
        .L3_ENTRIES (L3_ENTRIES),
        .L2_MW      (L2_MW),
        .L3_MW      (L3_MW)
    ) u_lookup (
        .clk          (clk),
        .rst_n        (rst_n),
        .cls          (lk_cls),
        .split_en     (cdp_en),
        .l2_ents      (l2_ents),
        .l3_ents      (l3_ents),
        .l2_mask      (l2_mask),
        .l3_code_mask (l3_code_mask),
        .l3_data_mask (l3_data_mask)
    );
endmodule

// File: rtl/cos_mask_table_chk.sv
// Checker for cos_mask_table: relates register requests to err, rd_valid
// and mask outputs over time. It is attached to the top by bind.
module cos_mask_table_chk
    import cos_pkg::*;
#(
    parameter int unsigned NUM_THREADS = 4,
    parameter int unsigned L2_CLASSES  = 4,
    parameter int unsigned L3_ENTRIES  = 8,
    parameter int unsigned L2_MW       = 8,
    parameter int unsigned L3_MW       = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_write,
    input logic [11:0]      req_addr,
    input logic [31:0]      req_wdata,
    input logic             rd_valid,
    input logic             err,
    input logic [L2_MW-1:0] l2_mask,
    input logic [L3_MW-1:0] l3_code_mask,
    input logic [L3_MW-1:0] l3_data_mask
);
    logic in_l2;
    logic in_l3;
    logic in_assoc;
    logic l2_ok;
    logic rst_q;
    logic unused_chk;

    assign unused_chk = ^req_wdata;
    assign in_l2    = req_addr >= L2_BASE && req_addr < L2_BASE + 12'(L2_CLASSES);
    assign in_l3    = req_addr >= L3_BASE && req_addr < L3_BASE + 12'(L3_ENTRIES);
    assign in_assoc = req_addr >= ASSOC_BASE && req_addr < ASSOC_BASE + 12'(NUM_THREADS);
    assign l2_ok    = run_of_ones(64'(req_wdata[L2_MW-1:0]));

    // Remember that reset was applied at the previous edge.
    always_ff @(posedge clk) rst_q <= !rst_n;

    // R1
    reset_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_q |-> (l2_mask == '1 && l3_code_mask == '1 && l3_data_mask == '1 && !err && !rd_valid));

    // R3
    bad_mask_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && in_l2 && !l2_ok) |=> err);

    // R3
    good_mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && in_l2 && l2_ok) |=> !err);

    // R10
    unmapped_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !in_l2 && !in_l3 && !in_assoc) |=> err);

    // R11
    read_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> (rd_valid && !err));

    // R6
    l2_contig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_of_ones(64'(l2_mask)));

    // R8
    l3_contig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_of_ones(64'(l3_code_mask)) && run_of_ones(64'(l3_data_mask)));
endmodule

bind cos_mask_table cos_mask_table_chk #(
    .NUM_THREADS (NUM_THREADS),
    .L2_CLASSES  (L2_CLASSES),
    .L3_ENTRIES  (L3_ENTRIES),
    .L2_MW       (L2_MW),
    .L3_MW       (L3_MW)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .req_addr     (req_addr),
    .req_wdata    (req_wdata),
    .rd_valid     (rd_valid),
    .err          (err),
    .l2_mask      (l2_mask),
    .l3_code_mask (l3_code_mask),
    .l3_data_mask (l3_data_mask)
);

// File: tb/sim_cos_mask_table.sv
// Directed bench for cos_mask_table. Each scenario task checks its own results.
module sim_cos_mask_table;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [1:0]  lk_thread = '0;
    logic        cdp_en = 1'b0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic        err;
    logic [7:0]  l2_mask;
    logic [11:0] l3_code_mask;
    logic [11:0] l3_data_mask;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cos_mask_table #(
        .NUM_THREADS (4),
        .CLS_W       (4),
        .L2_CLASSES  (4),
        .L3_ENTRIES  (8),
        .L2_MW       (8),
        .L3_MW       (12)
    ) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_write    (req_write),
        .req_addr     (req_addr),
        .req_wdata    (req_wdata),
        .lk_thread    (lk_thread),
        .cdp_en       (cdp_en),
        .rd_valid     (rd_valid),
        .rd_data      (rd_data),
        .err          (err),
        .l2_mask      (l2_mask),
        .l3_code_mask (l3_code_mask),
        .l3_data_mask (l3_data_mask)
    );

    task automatic expect_eq(input string req, input string what,
                             input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic reg_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic reg_read(input string req, input logic [11:0] a, input logic [31:0] exp);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        expect_eq("R11", "rd_valid", 32'(rd_valid), 32'd1);
        expect_eq(req, $sformatf("read 0x%0h", a), rd_data, exp);
    endtask

    task automatic look(input string req, input logic [1:0] thr, input logic split,
                        input logic [7:0] e2, input logic [11:0] ec, input logic [11:0] ed);
        @(negedge clk);
        lk_thread = thr; cdp_en = split;
        @(negedge clk);
        expect_eq(req, $sformatf("l2 thr%0d", thr), 32'(l2_mask), 32'(e2));
        expect_eq(req, $sformatf("l3 code thr%0d", thr), 32'(l3_code_mask), 32'(ec));
        expect_eq(req, $sformatf("l3 data thr%0d", thr), 32'(l3_data_mask), 32'(ed));
    endtask

    task automatic t_reset;
        expect_eq("R1", "l2_mask", 32'(l2_mask), 32'hFF);
        expect_eq("R1", "l3_code_mask", 32'(l3_code_mask), 32'hFFF);
        expect_eq("R1", "l3_data_mask", 32'(l3_data_mask), 32'hFFF);
        expect_eq("R1", "err", 32'(err), 32'd0);
        reg_read("R1", 12'hD10, 32'hFF);
        reg_read("R1", 12'hC97, 32'hFFF);
        reg_read("R1", 12'h103, 32'h0);
    endtask

    task automatic t_l2_write;
        reg_write(12'hD11, 32'hABCD_0F0F);
        expect_eq("R2", "err after good write", 32'(err), 32'd0);
        reg_read("R2", 12'hD11, 32'h0F);
        reg_write(12'hD13, 32'h3C);
        reg_read("R2", 12'hD13, 32'h3C);
    endtask

    task automatic t_reject;
        reg_write(12'hD11, 32'h5A);
        expect_eq("R3", "err after split run", 32'(err), 32'd1);
        reg_read("R3", 12'hD11, 32'h0F);
        expect_eq("R3", "err single pulse", 32'(err), 32'd0);
        reg_write(12'hD11, 32'h0000_0100);
        expect_eq("R3", "err after zero mask", 32'(err), 32'd1);
        reg_read("R3", 12'hD11, 32'h0F);
        reg_write(12'hC90, 32'h801);
        expect_eq("R3", "err after split l3", 32'(err), 32'd1);
        reg_read("R3", 12'hC90, 32'hFFF);
    endtask

    task automatic t_l3_write;
        reg_write(12'hC93, 32'h0F00_00F0);
        reg_read("R9", 12'hC93, 32'h0F0);
        reg_write(12'hC95, 32'h3F0);
        reg_write(12'hC96, 32'h00F);
        reg_write(12'hC97, 32'hFF0);
        expect_eq("R9", "err after good l3", 32'(err), 32'd0);
        reg_read("R9", 12'hC97, 32'hFF0);
    endtask

    task automatic t_latency;
        @(negedge clk);
        lk_thread = 2'd0; cdp_en = 1'b0;
        @(negedge clk);
        reg_write(12'h100, 32'h1);
        expect_eq("R5", "l2 before update", 32'(l2_mask), 32'hFF);
        @(negedge clk);
        expect_eq("R5", "l2 after update", 32'(l2_mask), 32'h0F);
    endtask

    task automatic t_assoc;
        reg_write(12'h101, 32'h13);
        reg_read("R4", 12'h101, 32'h3);
        reg_write(12'h102, 32'h5);
        reg_write(12'h103, 32'h9);
        look("R4", 2'd1, 1'b0, 8'h3C, 12'h0F0, 12'h0F0);
    endtask

    task automatic t_range_unified;
        look("R6", 2'd2, 1'b0, 8'hFF, 12'h3F0, 12'h3F0);
        look("R7", 2'd3, 1'b0, 8'hFF, 12'hFFF, 12'hFFF);
        look("R7", 2'd0, 1'b0, 8'h0F, 12'hFFF, 12'hFFF);
    endtask

    task automatic t_split;
        look("R8", 2'd1, 1'b1, 8'h3C, 12'hFF0, 12'h00F);
        look("R8", 2'd0, 1'b1, 8'h0F, 12'h0F0, 12'hFFF);
        look("R8", 2'd2, 1'b1, 8'hFF, 12'hFFF, 12'hFFF);
    endtask

    task automatic t_unmapped;
        reg_write(12'hD14, 32'h1);
        expect_eq("R10", "err l2 beyond depth", 32'(err), 32'd1);
        reg_read("R10", 12'hD14, 32'h0);
        reg_write(12'h104, 32'h2);
        expect_eq("R10", "err thread beyond", 32'(err), 32'd1);
        reg_write(12'hC98, 32'h1);
        expect_eq("R10", "err l3 beyond depth", 32'(err), 32'd1);
        reg_read("R10", 12'h103, 32'h9);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_l2_write();
        t_reject();
        t_l3_write();
        t_latency();
        t_assoc();
        t_range_unified();
        t_split();
        t_unmapped();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule